// File: doc/BRIEF.md
# Boot-Time Flash-to-SDRAM Block Copier

This block decides, right after reset, how the processor boots. A strap input picks one of two modes. In the direct mode the processor runs straight from flash: nothing is copied and the reset vector points at the uncached kernel view of flash. In the copy mode the block moves the first 16 KB of flash into the bottom of SDRAM. It does this one 32-bit word at a time, reading through a request/acknowledge port on the flash side and writing through a request/acknowledge port on the SDRAM side. The processor is held off for the whole copy. When the last word has landed, the block releases the processor and points the reset vector at the cached kernel view of SDRAM.

The flash port is assumed to return plain sequential words. Command sequencing, error correction and memory timing belong to the controllers behind the two ports. A new reset at any point abandons the copy in progress, and the whole sequence then starts again from the first word.

Top module: `nand_boot_copier`

## Requirements
- R1: With the strap low at the last reset cycle (direct mode), the block issues no flash read and no SDRAM write. `cpu_hold` is low and `copy_done` is high from the first clock edge after reset is released, and `reset_vector` is 0xBFC0_0000.
- R2: With the strap high at the last reset cycle (copy mode), exactly 4096 words are read. Read i (i = 0..4095) uses byte address 0x1FC0_0000 + 4*i. Each word is written unchanged to SDRAM.
- R3: The SDRAM write for word i uses byte address 4*i. Every SDRAM write address is word aligned and below 0x0000_4000.
- R4: Words strictly alternate between ports. The write request for a word rises only after that word's read acknowledge. The next read request rises only after the previous write acknowledge. The two requests are never high together.
- R5: A request stays high until it is acknowledged. The address (and, for writes, the data) does not change while the request waits.
- R6: `cpu_hold` is high and `copy_done` low in reset and throughout a copy. Both change in the cycle after the last SDRAM write acknowledge.
- R7: After a completed copy, `reset_vector` is 0x8000_0000.
- R8: The strap is taken from the last cycle in which reset is asserted. Strap changes after that have no effect on the mode, on port activity or on `reset_vector`.
- R9: Asserting reset during a copy aborts it. After reset is released, the copy restarts at word 0 (flash address 0x1FC0_0000, SDRAM address 0) and runs all 4096 words again.
- R10: Whenever `cpu_hold` is low, `reset_vector` stays stable until the next reset.
- R11: Once `copy_done` is high, it stays high and `cpu_hold` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_nand_strap | input | 1 | Boot mode strap: 1 = copy mode, 0 = direct mode |
| fl_rd_req | output | 1 | Flash read request, held until acknowledged |
| fl_rd_addr | output | 32 | Flash physical byte address |
| fl_rd_ack | input | 1 | Flash read acknowledge, one-cycle pulse with data |
| fl_rd_data | input | 32 | Flash read data, valid with acknowledge |
| sd_wr_req | output | 1 | SDRAM write request, held until acknowledged |
| sd_wr_addr | output | 32 | SDRAM physical byte address |
| sd_wr_data | output | 32 | SDRAM write data |
| sd_wr_ack | input | 1 | SDRAM write acknowledge, one-cycle pulse |
| cpu_hold | output | 1 | Holds the processor in reset while high |
| reset_vector | output | 32 | Virtual address of the first instruction fetch |
| copy_done | output | 1 | Boot sequence finished |

## Verification
The embedded assertions check these every cycle: the request/acknowledge discipline, the strict alternation between reading and writing, the SDRAM address window, silence on both ports in direct mode, the strap staying frozen after reset, and the reset vector staying stable once the processor runs. Only the bench scenarios can show the rest. That covers the exact word count, address sequence and data integrity of the copy, the release of the hold one cycle after the final acknowledge, and that strap toggling during a run changes nothing. It also covers a mid-copy reset restarting the transfer at word 0.

// File: rtl/nbc_pkg.sv
// Package: shared state encoding and fixed boot addresses for the block copier.
package nbc_pkg;
    typedef enum logic [1:0] {
        SEQ_DECIDE = 2'd0,
        SEQ_READ   = 2'd1,
        SEQ_WRITE  = 2'd2,
        SEQ_DONE   = 2'd3
    } seq_state_t;

    localparam logic [31:0] VEC_UNCACHED_FLASH = 32'hBFC0_0000;
    localparam logic [31:0] VEC_CACHED_SDRAM   = 32'h8000_0000;
    localparam logic [31:0] PHYS_FLASH_BASE    = 32'h1FC0_0000;
    localparam logic [31:0] PHYS_SDRAM_BASE    = 32'h0000_0000;
endpackage

// File: rtl/boot_strap_latch.sv
// Module: boot_strap_latch
// Captures the boot mode strap on every reset cycle and freezes it once reset
// is released. Assumes the strap is already synchronous to clk.
module boot_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_in,
    output logic nand_mode
);
    // Track the strap while in reset; hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) nand_mode <= strap_in;
    end

    // R8: mode never changes while out of reset
    assert_strap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(nand_mode));
endmodule

// File: rtl/boot_vector_sel.sv
// Module: boot_vector_sel
// Chooses the first-fetch virtual address from the latched boot mode.
// Assumes the mode input is stable outside reset.
module boot_vector_sel #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] VEC_NOR  = 32'hBFC0_0000,
    parameter logic [31:0] VEC_NAND = 32'h8000_0000
) (
    input  logic              nand_mode,
    output logic [ADDR_W-1:0] vector
);
    // Pick the cached SDRAM entry after a copy, uncached flash otherwise.
    always_comb begin
        vector = nand_mode ? ADDR_W'(VEC_NAND) : ADDR_W'(VEC_NOR);
    end
endmodule

// File: rtl/boot_copy_seq.sv
// Module: boot_copy_seq
// Word-by-word copy sequencer. After reset it either finishes at once (direct
// mode) or reads WORDS words from flash and writes each to SDRAM before the
// next read. Assumes one-cycle acknowledge pulses that arrive only while the
// matching request is high.
module boot_copy_seq
    import nbc_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          WORDS      = 4096,
    parameter logic [31:0] FLASH_BASE = 32'h1FC0_0000,
    parameter logic [31:0] SDRAM_BASE = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nand_mode,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              hold,
    output logic              done
);
    localparam int CNT_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int BYTE_SH  = $clog2(DATA_W / 8);
    localparam logic [ADDR_W-1:0] SD_LIMIT = ADDR_W'(SDRAM_BASE) + ADDR_W'(WORDS << BYTE_SH);

    seq_state_t        state_q;
    logic [CNT_W-1:0]  idx_q;
    logic [DATA_W-1:0] buf_q;
    logic              last_word;
    logic [ADDR_W-1:0] offset;

    assign last_word = (idx_q == CNT_W'(WORDS - 1));

    // Sequence state, word index and the word in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_DECIDE;
            idx_q   <= '0;
            buf_q   <= '0;
        end else begin
            case (state_q)
                SEQ_DECIDE: begin
                    idx_q   <= '0;
                    state_q <= nand_mode ? SEQ_READ : SEQ_DONE;
                end
                SEQ_READ: if (rd_ack) begin
                    buf_q   <= rd_data;
                    state_q <= SEQ_WRITE;
                end
                SEQ_WRITE: if (wr_ack) begin
                    if (last_word) begin
                        state_q <= SEQ_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= SEQ_READ;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // Port requests, addresses and status decoded from the state.
    always_comb begin
        offset  = ADDR_W'(idx_q) << BYTE_SH;
        rd_req  = (state_q == SEQ_READ);
        wr_req  = (state_q == SEQ_WRITE);
        rd_addr = ADDR_W'(FLASH_BASE) + offset;
        wr_addr = ADDR_W'(SDRAM_BASE) + offset;
        wr_data = buf_q;
        hold    = (state_q != SEQ_DONE);
        done    = (state_q == SEQ_DONE);
    end

    // R5: read request and address held until acknowledged
    assert_read_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
    // R5: write request, address and data held until acknowledged
    assert_write_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));
    // R4: a write starts only after a read acknowledge
    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(rd_ack));
    // R4: a read starts only after a write acknowledge or at sequence start
    assert_read_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> $past(wr_ack) || $past(state_q == SEQ_DECIDE));
    // R4: never both requests at once
    assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    // R3: writes aligned and inside the copy window
    assert_sdram_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr < SD_LIMIT) && (wr_addr[BYTE_SH-1:0] == '0));
    // R6: hold falls only on a write acknowledge or straight from the decision
    assert_hold_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(wr_ack) || $past(state_q == SEQ_DECIDE));
    // R11: done is sticky until reset
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !hold);
endmodule

// File: rtl/nand_boot_copier.sv
// Module: nand_boot_copier (top)
// Boot-mode selection and boot-block copy. Latches the strap, runs the copy
// sequencer and drives the processor hold and reset vector. Assumes both
// memory ports acknowledge with single-cycle pulses.
module nand_boot_copier
    import nbc_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          COPY_BYTES = 16384,
    parameter logic [31:0] FLASH_BASE = PHYS_FLASH_BASE,
    parameter logic [31:0] SDRAM_BASE = PHYS_SDRAM_BASE,
    parameter logic [31:0] VEC_NOR    = VEC_UNCACHED_FLASH,
    parameter logic [31:0] VEC_NAND   = VEC_CACHED_SDRAM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_nand_strap,
    output logic              fl_rd_req,
    output logic [ADDR_W-1:0] fl_rd_addr,
    input  logic              fl_rd_ack,
    input  logic [DATA_W-1:0] fl_rd_data,
    output logic              sd_wr_req,
    output logic [ADDR_W-1:0] sd_wr_addr,
    output logic [DATA_W-1:0] sd_wr_data,
    input  logic              sd_wr_ack,
    output logic              cpu_hold,
    output logic [ADDR_W-1:0] reset_vector,
    output logic              copy_done
);
    localparam int WORDS = COPY_BYTES / (DATA_W / 8);

    logic nand_mode;

    boot_strap_latch u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_in  (boot_nand_strap),
        .nand_mode (nand_mode)
    );

    boot_copy_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .WORDS      (WORDS),
        .FLASH_BASE (FLASH_BASE),
        .SDRAM_BASE (SDRAM_BASE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .nand_mode (nand_mode),
        .rd_req    (fl_rd_req),
        .rd_addr   (fl_rd_addr),
        .rd_ack    (fl_rd_ack),
        .rd_data   (fl_rd_data),
        .wr_req    (sd_wr_req),
        .wr_addr   (sd_wr_addr),
        .wr_data   (sd_wr_data),
        .wr_ack    (sd_wr_ack),
        .hold      (cpu_hold),
        .done      (copy_done)
    );

    boot_vector_sel #(
        .ADDR_W   (ADDR_W),
        .VEC_NOR  (VEC_NOR),
        .VEC_NAND (VEC_NAND)
    ) u_vec (
        .nand_mode (nand_mode),
        .vector    (reset_vector)
    );

    // R1: direct mode keeps both memory ports idle
    assert_direct_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_mode |-> !fl_rd_req && !sd_wr_req);
    // R10: vector stable while the processor runs
    assert_vector_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_hold && $past(!cpu_hold) |-> $stable(reset_vector));
    // R7: finished copy leaves the cached SDRAM vector
    assert_copy_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done && fl_rd_addr != ADDR_W'(FLASH_BASE) |-> reset_vector == ADDR_W'(VEC_NAND));
endmodule

// File: tb/test_nand_boot_copier.sv
module test_nand_boot_copier;
    localparam logic [31:0] FL_BASE = 32'h1FC0_0000;
    localparam logic [31:0] V_NOR   = 32'hBFC0_0000;
    localparam logic [31:0] V_NAND  = 32'h8000_0000;
    localparam int          NWORDS  = 4096;
    localparam int          WDOG    = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        fl_rd_req, sd_wr_req, cpu_hold, copy_done;
    logic [31:0] fl_rd_addr, sd_wr_addr, sd_wr_data, reset_vector;
    logic        fl_rd_ack = 1'b0;
    logic        sd_wr_ack = 1'b0;
    logic [31:0] fl_rd_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int fl_wait = 0;
    int sd_wait = 0;
    bit last_ack_seen = 0;

    nand_boot_copier i_nand_boot_copier (
        .clk (clk), .rst_n (rst_n), .boot_nand_strap (strap),
        .fl_rd_req (fl_rd_req), .fl_rd_addr (fl_rd_addr),
        .fl_rd_ack (fl_rd_ack), .fl_rd_data (fl_rd_data),
        .sd_wr_req (sd_wr_req), .sd_wr_addr (sd_wr_addr),
        .sd_wr_data (sd_wr_data), .sd_wr_ack (sd_wr_ack),
        .cpu_hold (cpu_hold), .reset_vector (reset_vector),
        .copy_done (copy_done)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] flash_word(logic [31:0] addr);
        return (addr * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            check(0, "WDOG", "watchdog expired", cycles, WDOG);
            finish_run();
        end
    end

    // Flash model: random latency, data derived from the address.
    always @(negedge clk) begin
        if (!rst_n) begin
            fl_rd_ack = 0; fl_wait = 0; rd_cnt = 0;
        end else if (fl_rd_ack) begin
            fl_rd_ack = 0;
        end else if (fl_rd_req) begin
            if (fl_wait == 0) begin
                check(fl_rd_addr == FL_BASE + 32'(rd_cnt) * 4, "R2/R9", "flash address",
                      fl_rd_addr, FL_BASE + 32'(rd_cnt) * 4);
                check(!sd_wr_req, "R4", "both requests high", 32'(sd_wr_req), 0);
                check(rd_cnt == wr_cnt, "R4", "read before previous write", rd_cnt, wr_cnt);
                fl_rd_data = flash_word(fl_rd_addr);
                fl_rd_ack = 1;
                rd_cnt++;
                fl_wait = $urandom % 3;
            end else fl_wait--;
        end
    end

    // SDRAM model: random latency, checks address and data of each write.
    always @(negedge clk) begin
        if (!rst_n) begin
            sd_wr_ack = 0; sd_wait = 0; wr_cnt = 0; last_ack_seen = 0;
        end else if (sd_wr_ack) begin
            sd_wr_ack = 0;
            if (last_ack_seen) begin
                check(!cpu_hold && copy_done, "R6", "release after last ack",
                      {cpu_hold, copy_done}, 32'h1);
                last_ack_seen = 0;
            end
        end else if (sd_wr_req) begin
            if (sd_wait == 0) begin
                check(sd_wr_addr == 32'(wr_cnt) * 4 && sd_wr_addr < 32'h4000, "R3",
                      "sdram address", sd_wr_addr, 32'(wr_cnt) * 4);
                check(sd_wr_data == flash_word(FL_BASE + 32'(wr_cnt) * 4), "R2", "sdram data",
                      sd_wr_data, flash_word(FL_BASE + 32'(wr_cnt) * 4));
                check(rd_cnt == wr_cnt + 1, "R4", "write without read", rd_cnt, wr_cnt + 1);
                check(cpu_hold && !copy_done, "R6", "hold during copy",
                      {cpu_hold, copy_done}, 32'h2);
                sd_wr_ack = 1;
                wr_cnt++;
                if (wr_cnt == NWORDS) last_ack_seen = 1;
                sd_wait = $urandom % 3;
            end else sd_wait--;
        end
    end

    task automatic do_reset(bit mode, int n);
        rst_n = 0;
        strap = ~mode;
        repeat (n) @(negedge clk);
        strap = mode;              // value present on the last reset cycle
        @(negedge clk);
        check(cpu_hold && !copy_done, "R6", "hold in reset", {cpu_hold, copy_done}, 32'h2);
        rst_n = 1;
    endtask

    task automatic wait_done(bit toggle);
        while (!copy_done) begin
            @(negedge clk);
            if (toggle) strap = 1'($urandom % 2);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(cpu_hold && !copy_done, "R6", "reset state", {cpu_hold, copy_done}, 32'h2);

        // Direct mode, strap toggled afterwards.
        do_reset(0, 2);
        @(negedge clk);
        check(!cpu_hold && copy_done, "R1", "direct mode release", {cpu_hold, copy_done}, 32'h1);
        check(reset_vector == V_NOR, "R1", "direct vector", reset_vector, V_NOR);
        for (int i = 0; i < 20; i++) begin
            strap = 1'($urandom % 2);
            @(negedge clk);
        end
        check(reset_vector == V_NOR, "R8", "strap change ignored", reset_vector, V_NOR);
        check(reset_vector == V_NOR, "R10", "vector stable", reset_vector, V_NOR);
        check(rd_cnt == 0 && wr_cnt == 0, "R1", "no port traffic", rd_cnt + wr_cnt, 0);
        check(copy_done && !cpu_hold, "R11", "done sticky", {cpu_hold, copy_done}, 32'h1);

        // Full copy with strap toggling during the run.
        do_reset(1, 3);
        wait_done(1);
        check(wr_cnt == NWORDS && rd_cnt == NWORDS, "R2", "word count", wr_cnt, NWORDS);
        check(reset_vector == V_NAND, "R7", "copy vector", reset_vector, V_NAND);
        check(reset_vector == V_NAND, "R8", "strap toggles ignored", reset_vector, V_NAND);
        repeat (10) @(negedge clk);
        check(copy_done && !cpu_hold, "R11", "done sticky after copy", {cpu_hold, copy_done}, 32'h1);
        check(reset_vector == V_NAND, "R10", "vector stable after copy", reset_vector, V_NAND);

        // Abort mid-copy, then restart from word 0.
        do_reset(1, 2);
        begin
            int stop_at = 50 + int'($urandom % 400);
            while (wr_cnt < stop_at) @(negedge clk);
            check(cpu_hold, "R9", "hold mid copy", 32'(cpu_hold), 1);
        end
        do_reset(1, 2);
        @(negedge clk);
        check(fl_rd_req && fl_rd_addr == FL_BASE, "R9", "restart at word 0", fl_rd_addr, FL_BASE);
        wait_done(0);
        check(wr_cnt == NWORDS, "R9", "full copy after abort", wr_cnt, NWORDS);
        check(reset_vector == V_NAND, "R7", "vector after restart", reset_vector, V_NAND);

        // Strap high early in reset but low on the last reset cycle: direct mode.
        rst_n = 0;
        strap = 1;
        repeat (3) @(negedge clk);
        strap = 0;
        @(negedge clk);
        rst_n = 1;
        strap = 1;
        repeat (5) @(negedge clk);
        check(reset_vector == V_NOR, "R8", "last reset cycle wins", reset_vector, V_NOR);
        check(rd_cnt == 0, "R8", "no copy started", rd_cnt, 0);

        finish_run();
    end
endmodule